// File: doc/BRIEF.md
# Serial Scan Register Access Port

This block gives a debug host access to a small trace-buffer register set through one 40-bit serial test data register. A TAP controller outside the block supplies three single-cycle strobes: capture, shift and update. On capture, the port loads the result of the previous read into the shift register. During shift, that result leaves on `tdo_o` while the next request enters on `tdi_i`. On update, an access state machine carries out the request in the shifted frame: either one register write or one register read, never both.

Reads are pipelined by one scan. A value requested in scan N comes back in scan N+1. A read of the trace RAM data address fetches the RAM word at the read pointer and then steps the pointer. A host that reads a burst of RAM words therefore sends an identification read on its final scan, so that no extra RAM word is consumed.

The access state machine has four states:
- `ST_IDLE` is the state after reset and after an access.
- `ST_LOADED` means a capture has happened.
- `ST_SHIFT` means bits are moving.
- `ST_ACCESS` is a single cycle in which the register file acts.

Its transitions are:
- capture moves any state except `ST_ACCESS` to `ST_LOADED`.
- shift moves `ST_IDLE`, `ST_LOADED` or `ST_SHIFT` to `ST_SHIFT`.
- update moves any state except `ST_ACCESS` to `ST_ACCESS`.
- `ST_ACCESS` always returns to `ST_IDLE` on the next cycle.

If strobes coincide, update takes priority over capture, and capture takes priority over shift.

Top module: `scan_reg_port`

## Requirements
- R1: The frame is 40 bits long and is shifted least significant bit first, one bit per shift strobe, with `tdo_o` showing the current bit 0. Frame bits 31..0 carry the data word, bits 38..32 carry the register address, and bit 39 is the direction flag (1 = write, 0 = read).
- R2: On capture, the shift register loads the holding register into bits 31..0 and zero into bits 39..32. The data returned by a scan is therefore the result of the read requested by the previous scan.
- R3: A read of address 0 returns the constant `ID_CODE`.
- R4: A read of address 1 returns `DEPTH`, and a read of address 2 returns `WIDTH`.
- R5: A read of address 3 returns `status_i`, zero-extended. A write to address 3 has no effect.
- R6: A read of address 4 returns `ram_rdata_i` for the RAM location at `ram_raddr_o`, then advances the read pointer by one. The pointer wraps from `DEPTH-1` to 0.
- R7: A write to address 5 loads the read pointer from data bits `PTR_W-1..0`. A read of address 5 returns the pointer, zero-extended.
- R8: A write to address 6 sets the write pointer (`wr_ptr_o`, `PTR_W` bits), a write to address 7 sets the trigger count (`trig_count_o`, `TRIG_W` bits), and a write to address 8 sets the control field (`ctrl_o`, `CTRL_W` bits). Each value reads back at the same address and drives its output.
- R9: Writes to addresses 0, 1, 2 and 4, and to addresses 9 to 127, change no state. Reads of addresses 9 to 127 return zero.
- R10: A write clears the holding register, so the scan after a write returns zero in its data field.
- R11: The read pointer changes only as the result of an update. Each update reading address 4 advances it exactly once, and reads of any other address leave it unchanged.
- R12: After reset, the holding register, read pointer, write pointer, trigger count and control field are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| capture_i | input | 1 | Capture strobe from the TAP controller |
| shift_i | input | 1 | Shift strobe from the TAP controller |
| update_i | input | 1 | Update strobe from the TAP controller |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out (current bit 0 of the shift register) |
| status_i | input | STAT_W | Buffer status flags, readable at address 3 |
| ram_rdata_i | input | 32 | Trace RAM word at `ram_raddr_o` (combinational) |
| ram_raddr_o | output | PTR_W | Trace RAM read pointer |
| wr_ptr_o | output | PTR_W | Trace RAM write pointer |
| trig_count_o | output | TRIG_W | Trigger count |
| ctrl_o | output | CTRL_W | Control field |

## Verification
The assertions take three things for granted about the inputs:
- At most one of the three strobes is high in any cycle.
- No strobe arrives during the single access cycle that follows an update.
- `ram_rdata_i` settles within the same cycle as the pointer.

The bench drives strobes only from one scan task, which keeps them exclusive. That task leaves an idle cycle after each update, and the bench models the RAM as a combinational function of `ram_raddr_o`.

// File: rtl/sap_pkg.sv
package sap_pkg;

    localparam int FRAME_W = 40;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 7;

    localparam logic [ADDR_W-1:0] ADR_IDENT  = 7'd0;
    localparam logic [ADDR_W-1:0] ADR_DEPTH  = 7'd1;
    localparam logic [ADDR_W-1:0] ADR_WIDTH  = 7'd2;
    localparam logic [ADDR_W-1:0] ADR_STATUS = 7'd3;
    localparam logic [ADDR_W-1:0] ADR_RAMDAT = 7'd4;
    localparam logic [ADDR_W-1:0] ADR_RDPTR  = 7'd5;
    localparam logic [ADDR_W-1:0] ADR_WRPTR  = 7'd6;
    localparam logic [ADDR_W-1:0] ADR_TRIG   = 7'd7;
    localparam logic [ADDR_W-1:0] ADR_CTRL   = 7'd8;

    // Bit 39 = direction, 38..32 = address, 31..0 = data
    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } scan_frame_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOADED,
        ST_SHIFT,
        ST_ACCESS
    } port_state_t;

endpackage

// File: rtl/sap_access_fsm.sv
module sap_access_fsm
    import sap_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        capture_i,
    input  logic        shift_i,
    input  logic        update_i,
    output logic        load_go,
    output logic        shift_go,
    output logic        access_go,
    output port_state_t state_o
);

    port_state_t state_q;
    port_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (update_i)       state_d = ST_ACCESS;
                else if (capture_i) state_d = ST_LOADED;
                else if (shift_i)   state_d = ST_SHIFT;
            end
            ST_LOADED: begin
                if (update_i)       state_d = ST_ACCESS;
                else if (capture_i) state_d = ST_LOADED;
                else if (shift_i)   state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (update_i)       state_d = ST_ACCESS;
                else if (capture_i) state_d = ST_LOADED;
            end
            ST_ACCESS: state_d = ST_IDLE;
        endcase
    end

    // Output process: strobes are ignored while the access cycle runs
    always_comb begin
        load_go   = 1'b0;
        shift_go  = 1'b0;
        access_go = 1'b0;
        unique case (state_q)
            ST_ACCESS: access_go = 1'b1;
            ST_IDLE, ST_LOADED, ST_SHIFT: begin
                load_go  = capture_i && !update_i;
                shift_go = shift_i && !capture_i && !update_i;
            end
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/sap_shift_reg.sv
module sap_shift_reg #(
    parameter int FRAME_W = 40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_go,
    input  logic               shift_go,
    input  logic [FRAME_W-1:0] load_val,
    input  logic               tdi_i,
    output logic [FRAME_W-1:0] frame_q,
    output logic               tdo_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q <= '0;
        end else if (load_go) begin
            frame_q <= load_val;
        end else if (shift_go) begin
            frame_q <= {tdi_i, frame_q[FRAME_W-1:1]};
        end
    end

    assign tdo_o = frame_q[0];

endmodule

// File: rtl/sap_reg_bank.sv
module sap_reg_bank
    import sap_pkg::*;
#(
    parameter int          DEPTH   = 16,
    parameter int          WIDTH   = 32,
    parameter logic [31:0] ID_CODE = 32'h4E7B_0C21,
    parameter int          STAT_W  = 4,
    parameter int          TRIG_W  = 32,
    parameter int          CTRL_W  = 2,
    localparam int         PTR_W   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              access_go,
    input  scan_frame_t       req,
    input  logic [STAT_W-1:0] status_i,
    input  logic [DATA_W-1:0] ram_rdata_i,
    output logic [PTR_W-1:0]  ram_raddr_o,
    output logic [PTR_W-1:0]  wr_ptr_o,
    output logic [TRIG_W-1:0] trig_count_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [DATA_W-1:0] hold_o
);

    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0]  rptr_q;
    logic [PTR_W-1:0]  rptr_next;
    logic [PTR_W-1:0]  wptr_q;
    logic [TRIG_W-1:0] trig_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] rd_val;

    assign rptr_next = (rptr_q == PTR_LAST) ? '0 : rptr_q + 1'b1;

    always_comb begin
        rd_val = '0;
        case (req.addr)
            ADR_IDENT:  rd_val = ID_CODE;
            ADR_DEPTH:  rd_val = DATA_W'(DEPTH);
            ADR_WIDTH:  rd_val = DATA_W'(WIDTH);
            ADR_STATUS: rd_val = DATA_W'(status_i);
            ADR_RAMDAT: rd_val = ram_rdata_i;
            ADR_RDPTR:  rd_val = DATA_W'(rptr_q);
            ADR_WRPTR:  rd_val = DATA_W'(wptr_q);
            ADR_TRIG:   rd_val = DATA_W'(trig_q);
            ADR_CTRL:   rd_val = DATA_W'(ctrl_q);
            default:    rd_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rptr_q <= '0;
            wptr_q <= '0;
            trig_q <= '0;
            ctrl_q <= '0;
            hold_q <= '0;
        end else if (access_go) begin
            if (req.wr) begin
                hold_q <= '0;
                case (req.addr)
                    ADR_RDPTR: rptr_q <= req.data[PTR_W-1:0];
                    ADR_WRPTR: wptr_q <= req.data[PTR_W-1:0];
                    ADR_TRIG:  trig_q <= req.data[TRIG_W-1:0];
                    ADR_CTRL:  ctrl_q <= req.data[CTRL_W-1:0];
                    default:   ;
                endcase
            end else begin
                hold_q <= rd_val;
                if (req.addr == ADR_RAMDAT) rptr_q <= rptr_next;
            end
        end
    end

    assign ram_raddr_o  = rptr_q;
    assign wr_ptr_o     = wptr_q;
    assign trig_count_o = trig_q;
    assign ctrl_o       = ctrl_q;
    assign hold_o       = hold_q;

endmodule

// File: rtl/scan_reg_port.sv
module scan_reg_port
    import sap_pkg::*;
#(
    parameter int          DEPTH   = 16,
    parameter int          WIDTH   = 32,
    parameter logic [31:0] ID_CODE = 32'h4E7B_0C21,
    parameter int          STAT_W  = 4,
    parameter int          TRIG_W  = 32,
    parameter int          CTRL_W  = 2,
    localparam int         PTR_W   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic              shift_i,
    input  logic              update_i,
    input  logic              tdi_i,
    output logic              tdo_o,
    input  logic [STAT_W-1:0] status_i,
    input  logic [31:0]       ram_rdata_i,
    output logic [PTR_W-1:0]  ram_raddr_o,
    output logic [PTR_W-1:0]  wr_ptr_o,
    output logic [TRIG_W-1:0] trig_count_o,
    output logic [CTRL_W-1:0] ctrl_o
);

    logic               load_go;
    logic               shift_go;
    logic               access_go;
    port_state_t        state;
    logic [FRAME_W-1:0] frame_q;
    logic [DATA_W-1:0]  hold;
    scan_frame_t        req;

    assign req = scan_frame_t'(frame_q);

    sap_access_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (capture_i),
        .shift_i   (shift_i),
        .update_i  (update_i),
        .load_go   (load_go),
        .shift_go  (shift_go),
        .access_go (access_go),
        .state_o   (state)
    );

    sap_shift_reg #(.FRAME_W(FRAME_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_go  (load_go),
        .shift_go (shift_go),
        .load_val ({{(FRAME_W-DATA_W){1'b0}}, hold}),
        .tdi_i    (tdi_i),
        .frame_q  (frame_q),
        .tdo_o    (tdo_o)
    );

    sap_reg_bank #(
        .DEPTH   (DEPTH),
        .WIDTH   (WIDTH),
        .ID_CODE (ID_CODE),
        .STAT_W  (STAT_W),
        .TRIG_W  (TRIG_W),
        .CTRL_W  (CTRL_W)
    ) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .access_go    (access_go),
        .req          (req),
        .status_i     (status_i),
        .ram_rdata_i  (ram_rdata_i),
        .ram_raddr_o  (ram_raddr_o),
        .wr_ptr_o     (wr_ptr_o),
        .trig_count_o (trig_count_o),
        .ctrl_o       (ctrl_o),
        .hold_o       (hold)
    );

endmodule

// File: rtl/sap_port_checker.sv
module sap_port_checker
    import sap_pkg::*;
#(
    parameter int  DEPTH  = 16,
    parameter int  TRIG_W = 32,
    parameter int  CTRL_W = 2,
    localparam int PTR_W  = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              capture_i,
    input logic              shift_i,
    input logic              update_i,
    input logic              access_go,
    input port_state_t       state,
    input logic [39:0]       frame_q,
    input logic [31:0]       hold,
    input logic [PTR_W-1:0]  ram_raddr_o,
    input logic [PTR_W-1:0]  wr_ptr_o,
    input logic [TRIG_W-1:0] trig_count_o,
    input logic [CTRL_W-1:0] ctrl_o
);

    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic       req_wr;
    logic [6:0] req_addr;
    logic       rd_ram;
    logic       wr_ro;

    assign req_wr   = frame_q[39];
    assign req_addr = frame_q[38:32];
    assign rd_ram   = access_go && !req_wr && (req_addr == ADR_RAMDAT);
    assign wr_ro    = access_go && req_wr &&
                      !(req_addr inside {ADR_RDPTR, ADR_WRPTR, ADR_TRIG, ADR_CTRL});

    assert_strobes_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({capture_i, shift_i, update_i}));

    assert_access_single_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACCESS) |=> (state == ST_IDLE));

    assert_rptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ram |=> ram_raddr_o == (($past(ram_raddr_o) == PTR_LAST) ? '0 : $past(ram_raddr_o) + 1'b1));

    assert_rptr_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !access_go |=> $stable(ram_raddr_o));

    assert_cfg_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !access_go |=> ($stable(ctrl_o) && $stable(trig_count_o) && $stable(wr_ptr_o)));

    assert_ro_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ro |=> ($stable(ctrl_o) && $stable(trig_count_o) && $stable(wr_ptr_o) && $stable(ram_raddr_o)));

    assert_write_clears_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (access_go && req_wr) |=> (hold == '0));

endmodule

bind scan_reg_port sap_port_checker #(
    .DEPTH  (DEPTH),
    .TRIG_W (TRIG_W),
    .CTRL_W (CTRL_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .capture_i    (capture_i),
    .shift_i      (shift_i),
    .update_i     (update_i),
    .access_go    (access_go),
    .state        (state),
    .frame_q      (frame_q),
    .hold         (hold),
    .ram_raddr_o  (ram_raddr_o),
    .wr_ptr_o     (wr_ptr_o),
    .trig_count_o (trig_count_o),
    .ctrl_o       (ctrl_o)
);

// File: tb/scan_reg_port_tb.sv
`timescale 1ns/1ps
module scan_reg_port_tb;

    localparam int          DEPTH = 16;
    localparam int          PTR_W = 4;
    localparam logic [31:0] ID    = 32'h4E7B_0C21;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        capture_i = 1'b0;
    logic        shift_i = 1'b0;
    logic        update_i = 1'b0;
    logic        tdi_i = 1'b0;
    logic        tdo_o;
    logic [3:0]  status_i = 4'h0;
    logic [31:0] ram_rdata_i;
    logic [3:0]  ram_raddr_o;
    logic [3:0]  wr_ptr_o;
    logic [31:0] trig_count_o;
    logic [1:0]  ctrl_o;

    int n_checks = 0;
    int n_fails  = 0;
    logic [39:0] got;

    always #4 clk = ~clk;

    function automatic logic [31:0] ram_word(input logic [3:0] a);
        return 32'h5A5A_0007 + {28'd0, a} * 32'h0001_0111;
    endfunction

    assign ram_rdata_i = ram_word(ram_raddr_o);

    scan_reg_port u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .capture_i    (capture_i),
        .shift_i      (shift_i),
        .update_i     (update_i),
        .tdi_i        (tdi_i),
        .tdo_o        (tdo_o),
        .status_i     (status_i),
        .ram_rdata_i  (ram_rdata_i),
        .ram_raddr_o  (ram_raddr_o),
        .wr_ptr_o     (wr_ptr_o),
        .trig_count_o (trig_count_o),
        .ctrl_o       (ctrl_o)
    );

    task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One full scan: capture, 40 shifts (LSB first), update, idle for the access cycle
    task automatic scan(input logic wr, input logic [6:0] addr, input logic [31:0] data,
                        output logic [39:0] out);
        logic [39:0] frame;
        frame = {wr, addr, data};
        @(negedge clk); capture_i = 1'b1;
        @(negedge clk); capture_i = 1'b0; shift_i = 1'b1;
        for (int i = 0; i < 40; i++) begin
            tdi_i  = frame[i];
            out[i] = tdo_o;
            @(negedge clk);
        end
        shift_i = 1'b0; update_i = 1'b1;
        @(negedge clk); update_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        check("R12 ctrl", {38'd0, ctrl_o}, 40'd0);
        check("R12 wptr", {36'd0, wr_ptr_o}, 40'd0);
        check("R12 trig", {8'd0, trig_count_o}, 40'd0);
        check("R12 rptr", {36'd0, ram_raddr_o}, 40'd0);
        scan(1'b0, 7'd0, 32'h0, got);
        check("R12 hold", got, 40'd0);
    endtask

    task automatic t_constants;
        scan(1'b0, 7'd1, 32'hFFFF_FFFF, got);
        check("R3 ident", got, {8'd0, ID});
        scan(1'b0, 7'd2, 32'h0, got);
        check("R4 depth", got, 40'd16);
        scan(1'b0, 7'd0, 32'h0, got);
        check("R4 width", got, 40'd32);
        check("R1 upper bits zero", {32'd0, got[39:32]}, 40'd0);
    endtask

    task automatic t_status;
        status_i = 4'b1011;
        scan(1'b0, 7'd3, 32'h0, got);
        scan(1'b1, 7'd3, 32'h0000_000F, got);
        check("R5 status read", got, 40'h0B);
        scan(1'b0, 7'd3, 32'h0, got);
        check("R10 after write", got, 40'd0);
        scan(1'b0, 7'd0, 32'h0, got);
        check("R5 write ignored", got, 40'h0B);
    endtask

    task automatic t_ram_burst;
        scan(1'b1, 7'd5, 32'd14, got);
        check("R7 rptr out", {36'd0, ram_raddr_o}, 40'd14);
        scan(1'b0, 7'd5, 32'h0, got);
        scan(1'b0, 7'd4, 32'h0, got);
        check("R7 rptr readback", got, 40'd14);
        scan(1'b0, 7'd4, 32'h0, got);
        check("R6 word14", got, {8'd0, ram_word(4'd14)});
        scan(1'b0, 7'd4, 32'h0, got);
        check("R6 word15", got, {8'd0, ram_word(4'd15)});
        scan(1'b0, 7'd0, 32'h0, got);
        check("R6 wrap word0", got, {8'd0, ram_word(4'd0)});
        check("R11 rptr after burst", {36'd0, ram_raddr_o}, 40'd1);
        scan(1'b0, 7'd0, 32'h0, got);
        check("R11 ident read keeps rptr", {36'd0, ram_raddr_o}, 40'd1);
    endtask

    task automatic t_config;
        scan(1'b1, 7'd6, 32'h0000_0009, got);
        scan(1'b1, 7'd7, 32'hABCD_1234, got);
        scan(1'b1, 7'd8, 32'h0000_0003, got);
        check("R8 wptr out", {36'd0, wr_ptr_o}, 40'd9);
        check("R8 trig out", {8'd0, trig_count_o}, 40'hABCD_1234);
        check("R8 ctrl out", {38'd0, ctrl_o}, 40'd3);
        scan(1'b0, 7'd6, 32'h0, got);
        scan(1'b0, 7'd7, 32'h0, got);
        check("R8 wptr read", got, 40'd9);
        scan(1'b0, 7'd8, 32'h0, got);
        check("R8 trig read", got, 40'hABCD_1234);
        scan(1'b0, 7'd0, 32'h0, got);
        check("R8 ctrl read", got, 40'd3);
    endtask

    task automatic t_ignored;
        scan(1'b1, 7'd0,   32'hFFFF_FFFF, got);
        scan(1'b1, 7'd1,   32'hFFFF_FFFF, got);
        scan(1'b1, 7'd2,   32'hFFFF_FFFF, got);
        scan(1'b1, 7'd4,   32'hFFFF_FFFF, got);
        scan(1'b1, 7'd9,   32'hFFFF_FFFF, got);
        scan(1'b1, 7'd127, 32'hFFFF_FFFF, got);
        check("R9 ctrl kept", {38'd0, ctrl_o}, 40'd3);
        check("R9 wptr kept", {36'd0, wr_ptr_o}, 40'd9);
        check("R9 trig kept", {8'd0, trig_count_o}, 40'hABCD_1234);
        check("R9 rptr kept", {36'd0, ram_raddr_o}, 40'd1);
        scan(1'b0, 7'd9, 32'h0, got);
        scan(1'b0, 7'd127, 32'h0, got);
        check("R9 addr9 reads zero", got, 40'd0);
        scan(1'b0, 7'd1, 32'h0, got);
        check("R9 addr127 reads zero", got, 40'd0);
        scan(1'b0, 7'd0, 32'h0, got);
        check("R9 depth after write", got, 40'd16);
        scan(1'b0, 7'd0, 32'h0, got);
        check("R9 ident after write", got, {8'd0, ID});
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_constants();
        t_status();
        t_ram_burst();
        t_config();
        t_ignored();
        summary();
        $finish;
    end

endmodule